// File: doc/BRIEF.md
# Horizontal Sync Lock Detector

This block watches a stream of horizontal sync detections, each a single-cycle pulse on the pixel clock. It judges every line against the position it expects the next sync to take. That prediction is the last anchor point plus a programmable nominal line length, counted in pixel clocks. A sync within a tolerance of ±TOL pixels of the prediction counts as locked for that line. A sync that comes earlier than the window is out of window and moves the anchor to itself. When no sync has arrived by the late edge of the window, the line is declared missing and the prediction free-runs forward by one line length, so the next window stays centred.

Two outputs report the result. `line_valid` carries the verdict of the most recent line and changes only when a new verdict is reached, so it toggles when sync timing wanders or pulses drop out. `unlock_irq_n` is an active-low per-field interrupt. It falls as soon as THRESH lines in the current field have been judged unlocked. It rises again at a field boundary that closes a field with fewer than THRESH unlocked lines. A field-start pulse from the vertical timing logic marks each field boundary.

Top module: `hlock_monitor`

## Requirements
- R1: While `rst_n` is low (synchronous), `line_valid` is 0 and `unlock_irq_n` is 1 on the following cycle. After reset no verdict is made until the first sync pulse, and that first pulse only sets the anchor, leaving `line_valid` at 0.
- R2: A sync pulse arriving d cycles after the anchor cycle, with `line_len`−TOL ≤ d ≤ `line_len`+TOL, sets `line_valid` to 1 on the next cycle and becomes the new anchor. Defaults: TOL=16.
- R3: A sync pulse with d < `line_len`−TOL is out of window. It sets `line_valid` to 0 on the next cycle, becomes the new anchor, and counts as an unlocked line.
- R4: If no sync pulse has arrived by d = `line_len`+TOL, the line is missing. `line_valid` goes to 0 on the next cycle, the line counts as unlocked, and the anchor advances by exactly `line_len`.
- R5: In cycles where no verdict is reached, `line_valid` keeps its value.
- R6: Unlocked lines are counted within the field, saturating at THRESH (default 128). The cycle after the THRESH-th unlocked verdict of a field, `unlock_irq_n` is 0, and it stays 0 for the rest of that field.
- R7: `field_start` clears the unlocked-line count. A verdict made in the same cycle as `field_start` counts toward the new field.
- R8: On `field_start`, `unlock_irq_n` becomes 1 on the next cycle if the field just closed had fewer than THRESH unlocked lines. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pulse | input | 1 | One-cycle horizontal sync detection |
| field_start | input | 1 | One-cycle pulse at each field boundary |
| line_len | input | LEN_W | Nominal line length in pixel clocks (must exceed 2·TOL+1) |
| line_valid | output | 1 | Verdict of the latest line: 1 = sync inside window |
| unlock_irq_n | output | 1 | Active-low unlock interrupt |

## Verification
The bench targets the window edges one pixel apart: d = L−16 and d = L+16 must be accepted, and d = L−17 must be rejected and re-anchor. A design with an off-by-one window would flip `line_valid` at one of these, and a design that re-anchored wrongly would misjudge every later line. Long runs with no sync check that the free-running prediction lands each missing verdict exactly one line length after the previous one; a drifting predictor would shift the miss times. Fields with exactly THRESH−1 and exactly THRESH unlocked lines, plus a field boundary that coincides with a miss verdict, show whether the interrupt threshold, its release and the attribution of a same-cycle verdict are correct.

// File: rtl/hlock_pkg.sv
// Shared types for the horizontal sync lock detector.
package hlock_pkg;

    // Per-cycle verdict on the line being tracked.
    typedef enum logic [1:0] {
        VERD_NONE = 2'd0,   // no decision this cycle
        VERD_OK   = 2'd1,   // sync inside the acceptance window
        VERD_OUT  = 2'd2,   // sync outside the window (re-anchors)
        VERD_MISS = 2'd3    // window closed without a sync
    } verdict_t;

    // True for verdicts that count as an unlocked line.
    function automatic logic is_unlocked(verdict_t v);
        return (v == VERD_OUT) || (v == VERD_MISS);
    endfunction

endpackage

// File: rtl/hlock_predictor.sv
// Sync position predictor and window judge.
// Counts pixel clocks since the last anchor. Each cycle it decides whether
// the line ends with an accepted sync, an out-of-window sync or a miss.
// Assumes line_len > 2*TOL+1 and line_len stays steady within a line.
module hlock_predictor
    import hlock_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int TOL   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic [LEN_W-1:0] line_len,
    output verdict_t         verdict,
    output logic             anchored,
    output logic [LEN_W:0]   pos
);
    localparam int PW = LEN_W + 1;

    logic [PW-1:0] win_lo;
    logic [PW-1:0] win_hi;

    // Window edges around the predicted sync position.
    always_comb begin
        win_lo = {1'b0, line_len} - PW'(TOL);
        win_hi = {1'b0, line_len} + PW'(TOL);
    end

    // Classify the current cycle.
    always_comb begin
        verdict = VERD_NONE;
        if (anchored) begin
            if (sync_pulse) begin
                verdict = (pos >= win_lo && pos <= win_hi) ? VERD_OK : VERD_OUT;
            end else if (pos >= win_hi) begin
                verdict = VERD_MISS;
            end
        end
    end

    // Position counter: restart on any sync, free-run by one line on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            anchored <= 1'b0;
            pos      <= '0;
        end else if (!anchored) begin
            if (sync_pulse) begin
                anchored <= 1'b1;
                pos      <= PW'(1);
            end
        end else begin
            case (verdict)
                VERD_OK, VERD_OUT: pos <= PW'(1);
                VERD_MISS:         pos <= PW'(TOL + 1);
                default:           pos <= pos + PW'(1);
            endcase
        end
    end

endmodule

// File: rtl/hlock_line_flag.sv
// Per-line lock flag.
// Holds the latest verdict and changes only when a verdict is made.
module hlock_line_flag
    import hlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_t verdict,
    output logic     line_valid
);
    // Capture the outcome of each judged line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_valid <= 1'b0;
        end else if (verdict != VERD_NONE) begin
            line_valid <= (verdict == VERD_OK);
        end
    end

endmodule

// File: rtl/hlock_unlock_tally.sv
// Per-field unlocked-line counter and active-low interrupt.
// Counts unlocked verdicts, saturating at THRESH, and clears at field start.
// The interrupt falls when the count reaches THRESH. It rises at a field
// start that closes a field below THRESH. Assumes THRESH >= 2.
module hlock_unlock_tally #(
    parameter int THRESH = 128,
    localparam int CW    = $clog2(THRESH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          unlock_evt,
    input  logic          field_start,
    output logic [CW-1:0] count,
    output logic          irq_n
);
    logic [CW-1:0] count_nxt;
    logic          reach;

    // Next count value and threshold crossing.
    always_comb begin
        reach = 1'b0;
        if (field_start) begin
            count_nxt = unlock_evt ? CW'(1) : '0;
        end else if (unlock_evt && count < CW'(THRESH)) begin
            count_nxt = count + CW'(1);
            reach     = (count == CW'(THRESH - 1));
        end else begin
            count_nxt = count;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_nxt;
        end
    end

    // Interrupt: set on threshold, release on a good field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else if (field_start) begin
            irq_n <= (count < CW'(THRESH)) ? 1'b1 : 1'b0;
        end else if (reach) begin
            irq_n <= 1'b0;
        end
    end

endmodule

// File: rtl/hlock_monitor.sv
// Horizontal sync lock detector, top level.
// Judges each line against a +/-TOL window around the predicted sync
// position and raises an active-low interrupt when THRESH or more lines of a
// field are unlocked. Assumes one-cycle sync and field_start pulses.
module hlock_monitor
    import hlock_pkg::*;
#(
    parameter int LEN_W  = 11,
    parameter int TOL    = 16,
    parameter int THRESH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic             field_start,
    input  logic [LEN_W-1:0] line_len,
    output logic             line_valid,
    output logic             unlock_irq_n
);
    localparam int CW = $clog2(THRESH + 1);

    verdict_t       verdict;
    logic           anchored_q;
    logic [LEN_W:0] pos_q;
    logic [CW-1:0]  unl_count;
    logic           unl_evt;

    // Unlocked-line strobe for the tally.
    always_comb unl_evt = is_unlocked(verdict);

    hlock_predictor #(.LEN_W(LEN_W), .TOL(TOL)) u_pred (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .line_len   (line_len),
        .verdict    (verdict),
        .anchored   (anchored_q),
        .pos        (pos_q)
    );

    hlock_line_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .verdict    (verdict),
        .line_valid (line_valid)
    );

    hlock_unlock_tally #(.THRESH(THRESH)) u_tally (
        .clk         (clk),
        .rst_n       (rst_n),
        .unlock_evt  (unl_evt),
        .field_start (field_start),
        .count       (unl_count),
        .irq_n       (unlock_irq_n)
    );

endmodule

// File: rtl/hlock_monitor_chk.sv
// Assertion checker for hlock_monitor, attached by bind.
// Relates the sync input and predictor position to the flag, and the tally
// count and field boundary to the interrupt.
module hlock_monitor_chk #(
    parameter int LEN_W  = 11,
    parameter int TOL    = 16,
    parameter int THRESH = 128,
    localparam int CW    = $clog2(THRESH + 1),
    localparam int PW    = LEN_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_pulse,
    input logic             field_start,
    input logic [LEN_W-1:0] line_len,
    input logic             line_valid,
    input logic             unlock_irq_n,
    input logic             anchored,
    input logic [LEN_W:0]   pos,
    input logic [CW-1:0]    unl_count
);
    logic [PW-1:0] lo;
    logic [PW-1:0] hi;
    logic          rst_seen;

    // Window edges recomputed from the nominal length.
    always_comb begin
        lo = {1'b0, line_len} - PW'(TOL);
        hi = {1'b0, line_len} + PW'(TOL);
    end

    // Remember that reset was sampled at the previous edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            reset_state_chk: assert (!line_valid && unlock_irq_n);
        end
    end

    // R2
    accept_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        anchored && sync_pulse && pos >= lo && pos <= hi |=> line_valid && pos == PW'(1));

    // R3
    early_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        anchored && sync_pulse && pos < lo |=> !line_valid && pos == PW'(1));

    // R4
    missing_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        anchored && !sync_pulse && pos == hi |=> !line_valid && pos == PW'(TOL + 1));

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_pulse && (!anchored || pos < hi) |=> $stable(line_valid));

    // R6
    irq_at_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unl_count == CW'(THRESH) |-> !unlock_irq_n);

    // R7
    field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> unl_count <= CW'(1));

    // R8
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start && unl_count < CW'(THRESH) |=> unlock_irq_n);

endmodule

bind hlock_monitor hlock_monitor_chk #(
    .LEN_W  (LEN_W),
    .TOL    (TOL),
    .THRESH (THRESH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_pulse   (sync_pulse),
    .field_start  (field_start),
    .line_len     (line_len),
    .line_valid   (line_valid),
    .unlock_irq_n (unlock_irq_n),
    .anchored     (anchored_q),
    .pos          (pos_q),
    .unl_count    (unl_count)
);

// File: tb/hlock_monitor_bench.sv
// Bench for hlock_monitor: directed window edges, long sync loss, field
// threshold cases and seeded random jitter, all against a cycle model.
module hlock_monitor_bench;
    localparam int LEN_W  = 11;
    localparam int TOL    = 16;
    localparam int THRESH = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_pulse = 1'b0;
    logic             field_start = 1'b0;
    logic [LEN_W-1:0] line_len = LEN_W'(80);
    logic             line_valid;
    logic             unlock_irq_n;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    // Model state
    bit     m_anch;
    longint t = 0;
    longint anchor = 0;
    bit     m_valid;
    bit     m_irq_n;
    int     m_cnt;
    string  m_tag;
    int     L = 80;

    always #2 clk = ~clk;

    hlock_monitor #(.LEN_W(LEN_W), .TOL(TOL), .THRESH(THRESH)) u_hlock_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_pulse   (sync_pulse),
        .field_start  (field_start),
        .line_len     (line_len),
        .line_valid   (line_valid),
        .unlock_irq_n (unlock_irq_n)
    );

    // Expected behaviour for one clock edge, from the requirements.
    task automatic model_edge(input bit s, input bit fs, input bit in_rst);
        longint d;
        bit evt, ok, unl;
        evt = 0; ok = 0;
        d = t - anchor;
        if (in_rst) begin
            m_anch = 0; m_valid = 0; m_irq_n = 1; m_cnt = 0; m_tag = "R1";
            return;
        end
        m_tag = m_anch ? "R5" : "R1";
        if (!m_anch) begin
            if (s) begin m_anch = 1; anchor = t; end
        end else if (s) begin
            evt = 1;
            ok = (d >= L - TOL) && (d <= L + TOL);
            anchor = t;
            m_tag = ok ? "R2" : "R3";
        end else if (d >= L + TOL) begin
            evt = 1; ok = 0;
            anchor = anchor + L;
            m_tag = "R4";
        end
        if (evt) m_valid = ok;
        unl = evt && !ok;
        if (fs) begin
            if (m_cnt < THRESH) begin
                if (!m_irq_n) m_tag = "R8";
                m_irq_n = 1;
            end else begin
                m_tag = "R8";
            end
            m_cnt = unl ? 1 : 0;
            if (unl) m_tag = "R7";
        end else if (unl && m_cnt < THRESH) begin
            m_cnt++;
            if (m_cnt == THRESH) begin m_irq_n = 0; m_tag = "R6"; end
        end
    endtask

    // Compare outputs against the model.
    task automatic compare();
        n_vec++;
        if (line_valid !== m_valid || unlock_irq_n !== m_irq_n) begin
            n_bad++;
            $display("FAIL %s cycle %0d: valid=%0b irq_n=%0b expected valid=%0b irq_n=%0b",
                     m_tag, t, line_valid, unlock_irq_n, m_valid, m_irq_n);
        end
    endtask

    // One clock cycle: drive, take the edge, update model, sample after edge.
    task automatic step(input bit s, input bit fs);
        sync_pulse  = s;
        field_start = fs;
        line_len    = LEN_W'(L);
        @(posedge clk);
        model_edge(s, fs, !rst_n);
        t++;
        #1;
        compare();
        sync_pulse  = 1'b0;
        field_start = 1'b0;
    endtask

    // A line whose sync lands gap cycles after the previous step sequence start.
    task automatic line(input int gap, input bit fs);
        for (int i = 0; i < gap - 1; i++) step(1'b0, 1'b0);
        step(1'b1, fs);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    // Step until the unlocked count in the model reaches the target.
    task automatic miss_until(input int target);
        while (m_cnt < target) step(1'b0, 1'b0);
    endtask

    // Directed explicit check helper.
    task automatic expect_bits(input string tag, input bit v, input bit irq);
        n_vec++;
        if (line_valid !== v || unlock_irq_n !== irq) begin
            n_bad++;
            $display("FAIL %s directed: valid=%0b irq_n=%0b expected valid=%0b irq_n=%0b",
                     tag, line_valid, unlock_irq_n, v, irq);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7319));
        // R1: reset state and first sync anchors only
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        rst_n = 1'b1;
        idle(10);
        step(1'b1, 1'b0);
        expect_bits("R1", 1'b0, 1'b1);

        // R2: nominal and window edges
        line(80, 1'b0);
        expect_bits("R2", 1'b1, 1'b1);
        line(80 - TOL, 1'b0);
        expect_bits("R2", 1'b1, 1'b1);
        line(80 + TOL, 1'b0);
        expect_bits("R2", 1'b1, 1'b1);
        // R3: one pixel early re-anchors
        line(80 - TOL - 1, 1'b0);
        expect_bits("R3", 1'b0, 1'b1);
        line(80, 1'b0);
        expect_bits("R2", 1'b1, 1'b1);
        // R5: flag holds between verdicts
        idle(20);
        expect_bits("R5", 1'b1, 1'b1);
        // R4: missing sync, then free-running windows
        idle(80 + TOL - 20);
        expect_bits("R4", 1'b0, 1'b1);
        line(80, 1'b0);
        expect_bits("R2", 1'b1, 1'b1);
        idle(5 * 80);

        // R6: a field reaching the threshold
        line(80, 1'b1);
        miss_until(THRESH - 1);
        expect_bits("R6", 1'b0, 1'b1);
        miss_until(THRESH);
        expect_bits("R6", 1'b0, 1'b0);
        idle(3 * 80);
        expect_bits("R6", 1'b0, 1'b0);
        // R8: boundary after a saturated field keeps the interrupt low
        step(1'b0, 1'b1);
        expect_bits("R8", 1'b0, 1'b0);
        // R8: field with THRESH-1 unlocked lines releases the interrupt
        miss_until(THRESH - 1);
        step(1'b0, 1'b1);
        expect_bits("R8", 1'b0, 1'b1);

        // R7: field boundary coincides with a miss verdict
        while (!(t - anchor == L + TOL)) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        miss_until(THRESH - 1);
        expect_bits("R7", 1'b0, 1'b1);
        miss_until(THRESH);
        expect_bits("R7", 1'b0, 1'b0);
        step(1'b0, 1'b1);

        // Random jitter, drops and field boundaries (R2 R3 R4 R5 R7)
        L = 96;
        line(96, 1'b0);
        for (int n = 0; n < 400; n++) begin
            int r;
            int gap;
            r = int'($urandom % 100);
            if (r < 12) gap = L + TOL + 1 + int'($urandom % 60);
            else        gap = L - 24 + int'($urandom % 49);
            line(gap, (n % 50) == 49);
        end
        idle(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule